// File: doc/BRIEF.md
# Dual Maskable Alarm Comparator

This block holds two alarm units for a real-time clock. Each unit compares the clock's running BCD time with alarm bytes that the host has written. The comparison happens only on the once-per-second update strobe. Bit 7 of every alarm byte is a mask bit. When it is set, that field takes no part in the match, so one bank of registers can express alarms from "every second" up to "once a month on a given date". The last byte of each alarm matches either the day of the week or the date of the month. Alarm 1 starts at seconds. Alarm 2 starts at minutes and is evaluated only at second 00.

A match sets a sticky flag that stays set until the host writes a zero to it. A control byte enables an interrupt for each alarm and chooses how the two active-low interrupt lines are shared. The time fields come from the timekeeping core. The host reaches the registers through a simple single-cycle write port at byte addresses 07h to 0Fh.

Top module: `alarm_match_unit`

## Requirements
- R1: After a synchronous active-low reset, both flags are 0, int_a_n and int_b_n are high, all alarm bytes are 00h, and the control byte holds routing-select=1 with both enables at 0.
- R2: Alarm 1 lives at 07h (seconds), 08h (minutes), 09h (hours) and 0Ah (day/date). On a strobe, bits 6:0 of each unmasked seconds, minutes or hours byte must equal the current field. The hours byte is compared bit for bit, including its 12/24 and AM/PM bits. A full match sets status bit 0.
- R3: A field whose alarm byte has bit 7 set is ignored in the match. With all four alarm 1 mask bits set, the flag sets on every strobe.
- R4: In a day/date byte, bit 6 = 1 compares bits 3:0 with the day of week. Bit 6 = 0 compares bits 5:0 with the date.
- R5: Alarm 2 lives at 0Bh (minutes), 0Ch (hours) and 0Dh (day/date). It uses the same field rules as alarm 1, but matches only on a strobe whose seconds equal 00. A match sets status bit 1. With all three masks set, it fires once a minute.
- R6: Matching time without a strobe leaves the flags unchanged.
- R7: Flags are sticky. Writing the status byte at 0Fh clears each flag whose data bit is 0. A data bit of 1 leaves that flag unchanged.
- R8: When a strobe match and a clearing status write land in the same cycle, the flag ends set.
- R9: Control byte 0Eh has bit 0 = alarm 1 enable, bit 1 = alarm 2 enable and bit 2 = routing select. With the routing select at 1, int_a_n is low exactly while flag 1 and its enable are set, and int_b_n is low exactly while flag 2 and its enable are set.
- R10: With the routing select at 0, int_a_n is low while either enabled alarm's flag is set, and int_b_n stays high.
- R11: A flag sets whether or not its enable is set. Clearing an enable releases the interrupt while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second update strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours byte bits 6:0 (mode, AM/PM, BCD) |
| cur_wday | input | 4 | Current day of week, 1 to 7 |
| cur_mday | input | 6 | Current date, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 2 | Sticky flags: bit 0 alarm 1, bit 1 alarm 2 |
| int_a_n | output | 1 | Active-low interrupt A |
| int_b_n | output | 1 | Active-low interrupt B |

## Verification
The bench first uses exact-match times that differ in a single field: seconds off by one, day of week against date, 24-hour against 12-hour hours. These show that every unmasked field, and no masked one, gates the flag. It then masks fields progressively, down to all masks set, to separate per-field masking from whole-alarm masking. It also strobes alarm 2 at non-zero seconds to confirm the implicit seconds check. Write patterns with ones and zeros in the status byte, a clearing write that collides with a strobe match, and each routing-select and enable combination show the clearing rule, set-over-clear priority and interrupt routing apart from the flag logic.

// File: rtl/alm_pkg.sv
// Package: shared constants and the time bundle for the alarm comparator.
// Assumes byte-wide registers addressed with a 4-bit pointer.
package alm_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int SEC_W     = 7;
    localparam int MIN_W     = 7;
    localparam int HOUR_W    = 7;
    localparam int WDAY_W    = 4;
    localparam int MDAY_W    = 6;
    localparam int NUM_ALM   = 2;
    localparam int A1_BYTES  = 4;
    localparam int A2_BYTES  = 3;
    localparam int ALM_BYTES = A1_BYTES + A2_BYTES;
    localparam int ALM_BASE  = 7;
    localparam int CTRL_ADDR = 14;
    localparam int STAT_ADDR = 15;
    localparam int CTRL_W    = 3;
    localparam int MASK_BIT  = 7;
    localparam int DYDT_BIT  = 6;
    localparam int ROUTE_BIT = 2;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
    } rtc_time_t;
endpackage

// File: rtl/alm_field_cmp.sv
// Module: one maskable 7-bit field compare (seconds, minutes or hours).
// Assumes the field sits in bits 6:0 of the alarm byte and bit 7 is the mask.
module alm_field_cmp
    import alm_pkg::*;
#(
    parameter int CUR_W = SEC_W
) (
    input  logic [BYTE_W-1:0] alm_byte,
    input  logic [CUR_W-1:0]  cur,
    output logic              hit
);
    // Field hits when masked or when the stored value equals the current one.
    always_comb begin
        hit = alm_byte[MASK_BIT] | (alm_byte[CUR_W-1:0] == cur);
    end
endmodule

// File: rtl/alm_unit.sv
// Module: one alarm unit; combines field hits into a match.
// With HAS_SEC=0 the unit has no seconds byte and matches only at second 00.
// Byte order inside alm: [seconds,] minutes, hours, day/date, lowest first.
module alm_unit
    import alm_pkg::*;
#(
    parameter int HAS_SEC = 1,
    parameter int NB      = (HAS_SEC != 0) ? A1_BYTES : A2_BYTES
) (
    input  logic [NB-1:0][BYTE_W-1:0] alm,
    input  rtc_time_t                 now,
    output logic                      hit
);
    localparam int OFS = (HAS_SEC != 0) ? 1 : 0;
    localparam int DD  = OFS + 2;

    logic       sec_hit;
    logic [1:0] mh_hit;
    logic       dd_hit;

    generate
        if (HAS_SEC != 0) begin : g_sec
            alm_field_cmp #(.CUR_W(SEC_W)) u_sec (
                .alm_byte (alm[0]),
                .cur      (now.sec),
                .hit      (sec_hit)
            );
        end else begin : g_nosec
            // Minute-granularity alarm: only the strobe at second 00 counts.
            always_comb begin
                sec_hit = (now.sec == '0);
            end
        end

        for (genvar k = 0; k < 2; k++) begin : g_mh
            alm_field_cmp #(.CUR_W(MIN_W)) u_mh (
                .alm_byte (alm[OFS+k]),
                .cur      ((k == 0) ? now.min : now.hour),
                .hit      (mh_hit[k])
            );
        end
    endgenerate

    // Day/date byte: bit 6 picks day of week or date as the compared field.
    always_comb begin
        if (alm[DD][MASK_BIT])
            dd_hit = 1'b1;
        else if (alm[DD][DYDT_BIT])
            dd_hit = (alm[DD][WDAY_W-1:0] == now.wday);
        else
            dd_hit = (alm[DD][MDAY_W-1:0] == now.mday);
    end

    // Whole alarm matches only when every field agrees.
    always_comb begin
        hit = sec_hit & (&mh_hit) & dd_hit;
    end
endmodule

// File: rtl/alm_regs.sv
// Module: alarm bytes, control bits and sticky flags.
// Assumes single-cycle writes. A strobe match outranks a clearing write.
module alm_regs
    import alm_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [BYTE_W-1:0]                  wr_data,
    input  logic [NUM_ALM-1:0]                 hit,
    output logic [ALM_BYTES-1:0][BYTE_W-1:0]   alm_bytes,
    output logic [CTRL_W-1:0]                  ctrl,
    output logic [NUM_ALM-1:0]                 flags
);
    logic stat_wr;
    logic ctrl_wr;

    // Decode the two single-address registers.
    always_comb begin
        stat_wr = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    end

    generate
        for (genvar j = 0; j < ALM_BYTES; j++) begin : g_byte
            // Alarm byte j: loaded by a write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alm_bytes[j] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(ALM_BASE + j)))
                    alm_bytes[j] <= wr_data;
            end
        end

        for (genvar i = 0; i < NUM_ALM; i++) begin : g_flag
            // Sticky flag i: set on a strobe match, cleared by writing 0.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags[i] <= 1'b0;
                else if (tick && hit[i])
                    flags[i] <= 1'b1;
                else if (stat_wr && !wr_data[i])
                    flags[i] <= 1'b0;
            end

            // R6: a flag may only rise in the cycle after a strobe.
            a_r6_rise_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flags[i]) |-> $past(tick));

            // R7: a flag may only fall after a status write with that bit at 0.
            a_r7_clear_by_zero : assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flags[i]) |-> $past(stat_wr && !wr_data[i]));
        end
    endgenerate

    // Control bits: enables and routing select; routing select resets to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= CTRL_W'(1 << ROUTE_BIT);
        else if (ctrl_wr)
            ctrl <= wr_data[CTRL_W-1:0];
    end
endmodule

// File: rtl/alarm_match_unit.sv
// Module: top of the dual alarm comparator with interrupt routing.
// Assumes tick is a one-cycle pulse and time inputs are stable when it is high.
module alarm_match_unit
    import alm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [SEC_W-1:0]     cur_sec,
    input  logic [MIN_W-1:0]     cur_min,
    input  logic [HOUR_W-1:0]    cur_hour,
    input  logic [WDAY_W-1:0]    cur_wday,
    input  logic [MDAY_W-1:0]    cur_mday,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [NUM_ALM-1:0]   alarm_flag,
    output logic                 int_a_n,
    output logic                 int_b_n
);
    rtc_time_t                         now;
    logic [ALM_BYTES-1:0][BYTE_W-1:0]  alm_bytes;
    logic [CTRL_W-1:0]                 ctrl;
    logic [NUM_ALM-1:0]                flags;
    logic [NUM_ALM-1:0]                hit;
    logic [NUM_ALM-1:0]                act;

    // Bundle the time inputs.
    always_comb begin
        now = '{sec: cur_sec, min: cur_min, hour: cur_hour,
                wday: cur_wday, mday: cur_mday};
    end

    alm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hit       (hit),
        .alm_bytes (alm_bytes),
        .ctrl      (ctrl),
        .flags     (flags)
    );

    alm_unit #(.HAS_SEC(1)) u_alm1 (
        .alm (alm_bytes[A1_BYTES-1:0]),
        .now (now),
        .hit (hit[0])
    );

    alm_unit #(.HAS_SEC(0)) u_alm2 (
        .alm (alm_bytes[ALM_BYTES-1:A1_BYTES]),
        .now (now),
        .hit (hit[1])
    );

    // Interrupt routing from enabled flags.
    always_comb begin
        act        = flags & ctrl[NUM_ALM-1:0];
        alarm_flag = flags;
        if (ctrl[ROUTE_BIT]) begin
            int_a_n = ~act[0];
            int_b_n = ~act[1];
        end else begin
            int_a_n = ~(|act);
            int_b_n = 1'b1;
        end
    end

    // R8: a strobe match always leaves its flag set in the next cycle.
    a_r8_match_wins : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tick && hit[0]) |-> alarm_flag[0]);
    a_r8_match_wins_b : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && tick && hit[1]) |-> alarm_flag[1]);

    // R10: interrupt B stays idle whenever routing select is 0.
    a_r10_b_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[ROUTE_BIT] |-> int_b_n);

    // R11: an active interrupt always has a set flag behind it.
    a_r11_int_needs_flag : assert property (@(posedge clk) disable iff (!rst_n)
        (!int_a_n || !int_b_n) |-> (|alarm_flag));
endmodule

// File: tb/tb_alarm_match_unit.sv
// Bench: scoreboard; the driver queues expected outputs, the monitor compares.
module tb_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [3:0] cur_wday = '0;
    logic [5:0] cur_mday = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] alarm_flag;
    logic       int_a_n, int_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [1:0] f;
        logic       a;
        logic       b;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    alarm_match_unit dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flag(alarm_flag), .int_a_n(int_a_n), .int_b_n(int_b_n)
    );

    // Monitor: compare each queued expectation shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (alarm_flag !== e.f || int_a_n !== e.a || int_b_n !== e.b) begin
                    errors++;
                    $display("FAIL %s: flags=%b a=%b b=%b expected flags=%b a=%b b=%b",
                             e.tag, alarm_flag, int_a_n, int_b_n, e.f, e.a, e.b);
                end
            end
        end
    end

    task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                            input logic [6:0] h, input logic [3:0] w,
                            input logic [5:0] d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; cur_mday = d;
    endtask

    // One cycle of stimulus; the expectation is for the result after the edge.
    task automatic cyc(input logic tk, input logic we, input logic [3:0] ad,
                       input logic [7:0] dt, input string tag,
                       input logic [1:0] f, input logic a, input logic b);
        exp_t e;
        @(negedge clk);
        tick = tk; wr_en = we; wr_addr = ad; wr_data = dt;
        @(posedge clk);
        #1;
        tick = 1'b0; wr_en = 1'b0;
        e.tag = tag; e.f = f; e.a = a; e.b = b;
        q.push_back(e);
    endtask

    task automatic wr(input logic [3:0] ad, input logic [7:0] dt, input string tag,
                      input logic [1:0] f, input logic a, input logic b);
        cyc(1'b0, 1'b1, ad, dt, tag, f, a, b);
    endtask

    task automatic tk(input string tag, input logic [1:0] f, input logic a, input logic b);
        cyc(1'b1, 1'b0, 4'h0, 8'h00, tag, f, a, b);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 4'h0, 8'h00, "R1 reset state", 2'b00, 1'b1, 1'b1);

        // Program alarm 1 on an exact time, enable both interrupts.
        set_time(7'h30, 7'h15, 7'h09, 4'd3, 6'h21);
        wr(4'h7, 8'h30, "R1 program sec", 2'b00, 1'b1, 1'b1);
        wr(4'h8, 8'h15, "R1 program min", 2'b00, 1'b1, 1'b1);
        wr(4'h9, 8'h09, "R1 program hour", 2'b00, 1'b1, 1'b1);
        wr(4'hA, 8'h21, "R1 program date", 2'b00, 1'b1, 1'b1);
        wr(4'hE, 8'h07, "R9 enable both", 2'b00, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 4'h0, 8'h00, "R6 match without strobe", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h31;
        tk("R2 seconds off by one", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h30;
        tk("R2 exact match", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h03, "R7 write ones keeps flag", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h02, "R7 write zero clears", 2'b00, 1'b1, 1'b1);

        // Day of week against date.
        wr(4'hA, 8'h43, "R4 select weekday", 2'b00, 1'b1, 1'b1);
        tk("R4 weekday match", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        cur_wday = 4'd4;
        tk("R4 weekday mismatch", 2'b00, 1'b1, 1'b1);
        wr(4'hA, 8'h21, "R4 select date", 2'b00, 1'b1, 1'b1);
        cur_mday = 6'h22;
        tk("R4 date mismatch", 2'b00, 1'b1, 1'b1);
        cur_mday = 6'h21;
        tk("R4 date match ignores weekday", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);

        // Masks.
        wr(4'h7, 8'h80, "R3 mask sec", 2'b00, 1'b1, 1'b1);
        wr(4'h8, 8'h80, "R3 mask min", 2'b00, 1'b1, 1'b1);
        wr(4'h9, 8'h80, "R3 mask hour", 2'b00, 1'b1, 1'b1);
        wr(4'hA, 8'h80, "R3 mask day", 2'b00, 1'b1, 1'b1);
        set_time(7'h47, 7'h02, 7'h23, 4'd4, 6'h05);
        tk("R3 all masked fires", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        wr(4'h7, 8'h05, "R3 seconds only", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h05;
        tk("R3 seconds-only match", 2'b01, 1'b0, 1'b1);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h06;
        tk("R3 seconds-only mismatch", 2'b00, 1'b1, 1'b1);

        // Alarm 2 exact time, implicit seconds 00.
        wr(4'hB, 8'h15, "R5 program min", 2'b00, 1'b1, 1'b1);
        wr(4'hC, 8'h09, "R5 program hour", 2'b00, 1'b1, 1'b1);
        wr(4'hD, 8'h21, "R5 program date", 2'b00, 1'b1, 1'b1);
        set_time(7'h00, 7'h15, 7'h09, 4'd4, 6'h21);
        tk("R5 match at second 00", 2'b10, 1'b1, 1'b0);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h30;
        tk("R5 no match at second 30", 2'b00, 1'b1, 1'b1);
        wr(4'hB, 8'h80, "R5 mask min", 2'b00, 1'b1, 1'b1);
        wr(4'hC, 8'h80, "R5 mask hour", 2'b00, 1'b1, 1'b1);
        wr(4'hD, 8'h80, "R5 mask day", 2'b00, 1'b1, 1'b1);
        set_time(7'h00, 7'h44, 7'h17, 4'd2, 6'h09);
        tk("R5 all masked at minute start", 2'b10, 1'b1, 1'b0);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h01;
        tk("R5 all masked at second 01", 2'b00, 1'b1, 1'b1);
        cur_sec = 7'h00;
        tk("R5 once a minute", 2'b10, 1'b1, 1'b0);

        // Routing and enables.
        wr(4'hE, 8'h03, "R10 shared line", 2'b10, 1'b0, 1'b1);
        wr(4'hE, 8'h01, "R11 enable off, flag kept", 2'b10, 1'b1, 1'b1);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        cyc(1'b1, 1'b1, 4'hF, 8'h00, "R8 match beats clear", 2'b10, 1'b1, 1'b1);

        // Hours compared with their mode bits.
        wr(4'hE, 8'h07, "R9 separate lines", 2'b10, 1'b1, 1'b0);
        wr(4'hF, 8'h00, "R7 clear", 2'b00, 1'b1, 1'b1);
        wr(4'h7, 8'h80, "R2 mask sec", 2'b00, 1'b1, 1'b1);
        wr(4'h9, 8'h49, "R2 12-hour 9 AM", 2'b00, 1'b1, 1'b1);
        set_time(7'h10, 7'h44, 7'h09, 4'd2, 6'h09);
        tk("R2 24-hour hours mismatch", 2'b00, 1'b1, 1'b1);
        cur_hour = 7'h49;
        tk("R2 12-hour hours match", 2'b01, 1'b0, 1'b1);
        cur_sec = 7'h00;
        tk("R9 both flags, both lines", 2'b11, 1'b0, 1'b0);
        wr(4'hE, 8'h03, "R10 both on line A", 2'b11, 1'b0, 1'b1);

        @(posedge clk);
        #5;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule